// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto the sixteen level inputs of a cascaded legacy interrupt controller pair. Each request line has its own one-byte route register, written and read through a small configuration port that takes a byte address, a four-lane byte-enable mask and 32-bit data. A route value below sixteen names the legacy line that the request drives. A value of sixteen or more turns that request line off.

Internally the router keeps a level bitmap with one bit per pair of legacy line and request line, at bit index `line*4 + request`. Each legacy output is the OR of its four-bit group, so several request lines can share one output. A write that lands on any route byte rebuilds the whole bitmap from the present input levels under the new routing. A separate combinational helper gives the request line used by a device's INTx pin. It takes the device number from the upper five bits of the device/function byte, adds it to the pin, subtracts one, and keeps the result modulo four.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte reads 0x80 (off) and all sixteen outputs are low.
- R2: The route bytes sit in the 32-bit word at byte offset 0x60. Byte lane i (bits 8i+7..8i) holds the route of request line i (A=0..D=3), and only lanes whose byte-enable bit is set are written. A read of that word returns the four route bytes. Reads of any other word return zero, and writes to any other word leave the route bytes unchanged.
- R3: Each output k is high exactly when at least one request line whose route byte equals k has a high input level.
- R4: A request line whose route byte is 16 or more has no effect on any output, whatever its input level.
- R5: When several request lines route to the same output, that output is the OR of their input levels.
- R6: After a route write, the outputs follow the new routing. The line the request used before goes low unless another request still drives it.
- R7: The slot helper output equals (pin + devfn[7:3] - 1) mod 4, computed combinationally.
- R8: An input level change or a route write shows at the outputs on the second rising edge after it is presented, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address; bits 1:0 are ignored |
| cfgByteEn | input | 4 | Byte-lane write enables |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr |
| pirqIn | input | 4 | Request line levels, A in bit 0 |
| irqOut | output | 16 | Legacy interrupt line levels |
| slotDevfn | input | 8 | Device/function byte for the slot helper |
| slotPin | input | 2 | INTx pin for the slot helper (0 = INTA) |
| slotPirq | output | 2 | Request line chosen by the slot helper |

## Verification
Inputs and route writes are registered first into the level bitmap and then into the output register, so their results are due on the second rising edge. The bench drives on the falling edge and samples the outputs at the falling edge after that second rising edge. One directed check also samples after only the first edge to confirm the old value still holds there. Read data and the slot helper are combinational, so the bench samples them a short delay after it changes the address or the helper inputs.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  parameter int NUM_PIRQ = 4;
  parameter int ROUTE_W  = 8;

  typedef struct packed {
    logic [NUM_PIRQ-1:0] laneWe;  // per-request route byte write
    logic                rebuild; // routing changed, resample levels
  } pirqStrobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_router_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input  logic                             cfgWrEn,
  input  logic [ADDR_W-1:0]                cfgAddr,
  input  logic [DATA_W/8-1:0]              cfgByteEn,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeBus,
  output logic [DATA_W-1:0]                cfgRdData,
  output pirqStrobe_t                      strobe
);
  localparam int LANES = DATA_W / 8;

  logic wordHit;
  assign wordHit = (cfgAddr[ADDR_W-1:2] == ROUTE_BASE[ADDR_W-1:2]);

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_lane
    if (i < LANES) begin : g_map
      assign strobe.laneWe[i] = cfgWrEn & wordHit & cfgByteEn[i];
    end else begin : g_none
      assign strobe.laneWe[i] = 1'b0;
    end
  end

  assign strobe.rebuild = |strobe.laneWe;

  always_comb begin
    cfgRdData = '0;
    if (wordHit) cfgRdData[NUM_PIRQ*ROUTE_W-1:0] = routeBus;
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  pirqStrobe_t                      strobe,
  input  logic [DATA_W-1:0]                cfgWrData,
  input  logic [NUM_PIRQ-1:0]              pirqIn,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeBus,
  output logic [NUM_IRQ-1:0]               irqOut
);
  localparam int LEVEL_W = NUM_IRQ * NUM_PIRQ;
  localparam logic [ROUTE_W-1:0] ROUTE_OFF = 8'h80;

  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeReg, routeNext;
  logic [LEVEL_W-1:0] levelMap, levelNext;

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
    assign routeNext[p] = (strobe.rebuild && strobe.laneWe[p])
                          ? cfgWrData[p*ROUTE_W +: ROUTE_W] : routeReg[p];
    always_ff @(posedge clk) begin
      if (!rstN) routeReg[p] <= ROUTE_OFF;
      else       routeReg[p] <= routeNext[p];
    end
  end

  // bit (line*NUM_PIRQ + request): request level under next routing
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_req
      assign levelNext[g*NUM_PIRQ + p] =
        pirqIn[p] && (routeNext[p] == ROUTE_W'(g));
    end
    always_ff @(posedge clk) begin
      if (!rstN) irqOut[g] <= 1'b0;
      else       irqOut[g] <= |levelMap[g*NUM_PIRQ +: NUM_PIRQ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) levelMap <= '0;
    else       levelMap <= levelNext;
  end

  assign routeBus = routeReg;
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle (
  input  logic [7:0] slotDevfn,
  input  logic [1:0] slotPin,
  output logic [1:0] slotPirq
);
  logic [4:0] devNum;
  assign devNum   = slotDevfn[7:3];
  assign slotPirq = slotPin + devNum[1:0] - 2'd1;
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W/8-1:0] cfgByteEn,
  input  logic [DATA_W-1:0]   cfgWrData,
  output logic [DATA_W-1:0]   cfgRdData,
  input  logic [NUM_PIRQ-1:0] pirqIn,
  output logic [NUM_IRQ-1:0]  irqOut,
  input  logic [7:0]          slotDevfn,
  input  logic [1:0]          slotPin,
  output logic [1:0]          slotPirq
);
  pirqStrobe_t strobe;
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeBus;

  pirq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROUTE_BASE(ROUTE_BASE)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .routeBus(routeBus), .cfgRdData(cfgRdData), .strobe(strobe)
  );

  pirq_datapath #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .pirqIn(pirqIn), .routeBus(routeBus), .irqOut(irqOut)
  );

  pirq_swizzle u_swz (
    .slotDevfn(slotDevfn), .slotPin(slotPin), .slotPirq(slotPirq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             cfgWrEn,
  input logic [ADDR_W-1:0]                cfgAddr,
  input logic [DATA_W-1:0]                cfgRdData,
  input logic [NUM_PIRQ-1:0]              pirqIn,
  input logic [NUM_IRQ-1:0]               irqOut,
  input logic [7:0]                       slotDevfn,
  input logic [1:0]                       slotPin,
  input logic [1:0]                       slotPirq,
  input logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeBus
);
  function automatic logic [NUM_IRQ-1:0] wantMap(
      input logic [NUM_PIRQ-1:0] lv,
      input logic [NUM_PIRQ-1:0][ROUTE_W-1:0] rt);
    logic [NUM_IRQ-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PIRQ; p++)
      if (lv[p] && rt[p] < ROUTE_W'(NUM_IRQ)) m[rt[p][3:0]] = 1'b1;
    return m;
  endfunction

  logic allOff;
  assign allOff = (routeBus[0] >= 8'd16) && (routeBus[1] >= 8'd16) &&
                  (routeBus[2] >= 8'd16) && (routeBus[3] >= 8'd16);

  // R3, R5, R8: with routing steady, outputs follow inputs two edges later
  p_or_map_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgWrEn) && !$past(cfgWrEn, 2)) |->
      irqOut == wantMap($past(pirqIn, 2), $past(routeBus)));

  // R4: every request off for two cycles keeps all outputs low
  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(allOff) && $past(allOff, 2)) |-> irqOut == '0);

  // R2: other words read as zero
  p_other_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr[ADDR_W-1:2] != ROUTE_BASE[ADDR_W-1:2]) |-> cfgRdData == '0);

  // R2: route bytes hold without a write
  p_route_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(routeBus));

  // R7: device number one maps the pin straight through
  p_swz_dev1_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slotDevfn[7:3] == 5'd1) |-> slotPirq == slotPin);
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROUTE_BASE(ROUTE_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgRdData(cfgRdData), .pirqIn(pirqIn), .irqOut(irqOut),
  .slotDevfn(slotDevfn), .slotPin(slotPin), .slotPirq(slotPirq),
  .routeBus(routeBus)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h60;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [3:0]  pirqIn = '0;
  logic [15:0] irqOut;
  logic [7:0]  slotDevfn = 8'h08;
  logic [1:0]  slotPin = '0;
  logic [1:0]  slotPirq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .pirqIn(pirqIn), .irqOut(irqOut), .slotDevfn(slotDevfn),
    .slotPin(slotPin), .slotPirq(slotPirq)
  );

  // {route word, input levels, expected outputs}
  localparam logic [51:0] VEC [8] = '{
    {32'h0B0A0509, 4'b0001, 16'h0200},
    {32'h0B0A0509, 4'b1111, 16'h0E20},
    {32'h05050505, 4'b0100, 16'h0020},
    {32'h05050505, 4'b0000, 16'h0000},
    {32'h0F800300, 4'b1111, 16'h8009},
    {32'h10FF0E01, 4'b1111, 16'h4002},
    {32'h07070C0C, 4'b1010, 16'h1080},
    {32'h07070C0C, 4'b0101, 16'h1080}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic readWord(input logic [7:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", 32'(irqOut), 32'h0);
    readWord(8'h60, rd);
    check("R1 routes", rd, 32'h80808080);

    // R4 inputs high while all routes off
    pirqIn = 4'b1111;
    settle();
    check("R4 all off", 32'(irqOut), 32'h0);

    // table walk: R3 R5 R4 R2
    for (int i = 0; i < 8; i++) begin
      cfgWrite(8'h60, 4'hF, VEC[i][51:20]);
      pirqIn = VEC[i][19:16];
      settle();
      @(negedge clk);
      check("R3/R5 vector", 32'(irqOut), 32'(VEC[i][15:0]));
      readWord(8'h61, rd);
      check("R2 readback", rd, VEC[i][51:20]);
    end

    // R2 partial byte enables, other words
    cfgWrite(8'h60, 4'hF, 32'h80808080);
    cfgWrite(8'h60, 4'b0010, 32'hAABB05CC);
    readWord(8'h60, rd);
    check("R2 lane write", rd, 32'h80800580);
    cfgWrite(8'h64, 4'hF, 32'h01010101);
    readWord(8'h60, rd);
    check("R2 other write ignored", rd, 32'h80800580);
    readWord(8'h64, rd);
    check("R2 other read zero", rd, 32'h0);
    readWord(8'h5C, rd);
    check("R2 lower read zero", rd, 32'h0);

    // R8 latency on input change: request B routed to 5
    pirqIn = 4'b0000;
    settle();
    @(negedge clk);
    pirqIn = 4'b0010;
    @(posedge clk); @(negedge clk);
    check("R8 first edge", 32'(irqOut), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 second edge", 32'(irqOut), 32'h0020);

    // R6 reroute: A to 3, then to 4
    cfgWrite(8'h60, 4'hF, 32'h80808003);
    pirqIn = 4'b0001;
    settle();
    check("R6 before", 32'(irqOut), 32'h0008);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h60; cfgByteEn = 4'b0001; cfgWrData = 32'h00000004;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
    check("R8 write first edge", 32'(irqOut), 32'h0008);
    @(posedge clk); @(negedge clk);
    check("R6 after", 32'(irqOut), 32'h0010);

    // R4 disabling a live request drops its line
    cfgWrite(8'h60, 4'b0001, 32'h00000010);
    settle();
    check("R4 disable", 32'(irqOut), 32'h0);

    // R7 slot helper
    slotDevfn = 8'h08; slotPin = 2'd2; #1;
    check("R7 dev1 pin2", 32'(slotPirq), 32'd2);
    slotDevfn = 8'h00; slotPin = 2'd0; #1;
    check("R7 dev0 pin0", 32'(slotPirq), 32'd3);
    slotDevfn = 8'h18; slotPin = 2'd3; #1;
    check("R7 dev3 pin3", 32'(slotPirq), 32'd1);
    slotDevfn = 8'h25; slotPin = 2'd1; #1;
    check("R7 dev4 fn5 pin1", 32'(slotPirq), 32'd0);

    finishRun();
  end
endmodule